// File: doc/BRIEF.md
# Bitplane Framebuffer Pixel Scanner

The scanner reads a byte-wide framebuffer and turns it into a stream of palette indices for a raster display with 256 lines of 256 pixels. Each framebuffer address covers a group of four horizontal pixels on one line. The address is column-major: its upper six bits pick the four-pixel column group and its lower eight bits pick the line. The framebuffer has two planes. The lower plane holds a color-attribute byte. The upper plane, 0x4000 bytes higher, holds a pixel-data byte.

A pixel-data byte carries two bitplanes, one in each nibble. Pixel n of the group takes bitplane 0 from bit 7-n and bitplane 1 from bit 3-n. The leftmost pixel therefore uses the top bit of each nibble. The 2-bit pixel value is joined with the low three bits of the attribute byte to form a 5-bit index into a 32-entry color table.

Raster timing controls the block. A line-start pulse begins a line, and a frame-start pulse that arrives with it makes that line number 0. The scanner then fetches each group's two bytes through a synchronous read port and shows the pixels on consecutive clocks. It issues no reads while blanking.

Top module: `bpscan_top`

## Requirements
- R1: While reset is held, and after it until the first line start, `pixValid` is 0, `pixIdx` is 0 and `memRd` is 0.
- R2: Count as cycle 0 the cycle after the edge that samples `lineStart` high. `pixValid` is then 1 in cycles 3 through 258 and 0 in cycles 259 onward until the next line start. `pixX` equals the cycle number minus 3, so it runs 0 to 255 in step.
- R3: A line start with `frameStart` high sets `pixY` to 0. A line start without it raises `pixY` by 1, and 255 wraps to 0. `pixY` holds its value for the whole line.
- R4: Group g (g = 0..63) of line y is fetched in two reads. In cycle 4g the scanner reads the attribute byte at address {g, y}, with bit 14 = 0. In cycle 4g+1 it reads the pixel byte at the same address with bit 14 = 1. Read data is expected on `memData` in the cycle after the read.
- R5: `memRd` is 0 in every cycle that R4 does not name, including cycles 2 and 3 of every group, cycles 256 and later, and all blanking.
- R6: For pixel x of line y, the scanner uses the pixel byte P of address {x[7:2], y} and sets n = x[1:0]. Bitplane 0 is P[7-n] and bitplane 1 is P[3-n].
- R7: During active output, `pixIdx` = {A[2:0], bitplane 1, bitplane 0}, where A is the attribute byte of the same address.
- R8: Whenever `pixValid` is 0, `pixIdx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one pixel slot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-cycle pulse that starts a line |
| frameStart | input | 1 | With lineStart, marks line 0 |
| memRd | output | 1 | Framebuffer read strobe |
| memAddr | output | 15 | Read address: bit 14 selects the plane, [13:8] the group, [7:0] the line |
| memData | input | 8 | Read data, one cycle after memRd |
| pixValid | output | 1 | Active-video pixel strobe |
| pixX | output | 8 | Horizontal pixel position (0 when not valid) |
| pixY | output | 8 | Current line number |
| pixIdx | output | 5 | Palette index, 0 outside active video |

## Verification
Some properties are checked on every cycle. The index is zero whenever no pixel is valid. Every attribute read is followed at once by the pixel-plane read of the same address. The X position advances by one across a line. The line number stays steady while pixels are shown. No read occurs in the last stretch of a line. Other behaviours only the bench's scenarios can show. These are the absolute cycle of each read, the bit-exact unpacking of both nibbles into indices against known memory contents, and the line numbering across a full 256-line frame with wraparound and a frame restart.

// File: rtl/bpscan_pkg.sv
package bpscan_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic rdAttr;   // issue attribute-plane read
    logic rdPix;    // issue pixel-plane read
    logic capAttr;  // capture attribute byte into prefetch stage
    logic capPix;   // move prefetch stage into display stage
    logic show;     // active video slot
  } scanStrb_t;

endpackage

// File: rtl/bpscan_ctrl.sv
module bpscan_ctrl
  import bpscan_pkg::*;
#(
  parameter int GRP_W  = 6,
  parameter int LINE_W = 8,
  parameter int SUB_W  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lineStart,
  input  logic                   frameStart,
  output scanStrb_t              strb,
  output logic [GRP_W-1:0]       fetchGrp,
  output logic [GRP_W+SUB_W-1:0] xPos,
  output logic [SUB_W-1:0]       subIdx,
  output logic [LINE_W-1:0]      lineY
);
  localparam int X_W   = GRP_W + SUB_W;
  localparam int CNT_W = X_W + 1;
  localparam logic [CNT_W-1:0] FETCH = CNT_W'(1 << X_W);
  localparam logic [CNT_W-1:0] LEAD  = CNT_W'(3);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'((1 << X_W) + 2);

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [SUB_W-1:0] phase;
  logic             fetchWin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run   <= 1'b0;
      cnt   <= '0;
      lineY <= '0;
    end else if (lineStart) begin
      run   <= 1'b1;
      cnt   <= '0;
      lineY <= frameStart ? '0 : lineY + 1'b1;
    end else if (run) begin
      if (cnt == LAST) run <= 1'b0;
      else             cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    phase        = cnt[SUB_W-1:0];
    fetchWin     = run && (cnt < FETCH);
    strb.rdAttr  = fetchWin && (phase == SUB_W'(0));
    strb.rdPix   = fetchWin && (phase == SUB_W'(1));
    strb.capAttr = fetchWin && (phase == SUB_W'(1));
    strb.capPix  = fetchWin && (phase == SUB_W'(2));
    strb.show    = run && (cnt >= LEAD);
    fetchGrp     = cnt[X_W-1:SUB_W];
    xPos         = strb.show ? X_W'(cnt - LEAD) : '0;
    subIdx       = xPos[SUB_W-1:0];
  end

endmodule

// File: rtl/bpscan_dp.sv
module bpscan_dp
  import bpscan_pkg::*;
#(
  parameter int GRP_W  = 6,
  parameter int LINE_W = 8,
  parameter int SUB_W  = 2,
  parameter int IDX_W  = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  scanStrb_t                     strb,
  input  logic [GRP_W-1:0]              fetchGrp,
  input  logic [SUB_W-1:0]              subIdx,
  input  logic [LINE_W-1:0]             lineY,
  input  logic [2*(1<<SUB_W)-1:0]       memData,
  output logic                          memRd,
  output logic [GRP_W+LINE_W:0]         memAddr,
  output logic [IDX_W-1:0]              pixIdx
);
  localparam int NIB    = 1 << SUB_W;
  localparam int DATA_W = 2 * NIB;
  localparam int ATTR_W = IDX_W - 2;

  logic [ATTR_W-1:0] attrHold;
  logic [ATTR_W-1:0] curAttr;
  logic [DATA_W-1:0] curPix;
  logic [NIB-1:0]    plane0Nib, plane1Nib;
  logic [SUB_W-1:0]  bitSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      attrHold <= '0;
      curAttr  <= '0;
      curPix   <= '0;
    end else begin
      if (strb.capAttr) attrHold <= memData[ATTR_W-1:0];
      if (strb.capPix) begin
        curAttr <= attrHold;
        curPix  <= memData;
      end
    end
  end

  always_comb begin
    memRd     = strb.rdAttr | strb.rdPix;
    memAddr   = {strb.rdPix, fetchGrp, lineY};
    plane0Nib = curPix[DATA_W-1:NIB];
    plane1Nib = curPix[NIB-1:0];
    bitSel    = ~subIdx;  // leftmost pixel takes the nibble MSB
    pixIdx    = strb.show ? {curAttr, plane1Nib[bitSel], plane0Nib[bitSel]} : '0;
  end

endmodule

// File: rtl/bpscan_top.sv
module bpscan_top
  import bpscan_pkg::*;
#(
  parameter int GRP_W  = 6,
  parameter int LINE_W = 8,
  parameter int SUB_W  = 2,
  parameter int IDX_W  = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lineStart,
  input  logic                      frameStart,
  output logic                      memRd,
  output logic [GRP_W+LINE_W:0]     memAddr,
  input  logic [2*(1<<SUB_W)-1:0]   memData,
  output logic                      pixValid,
  output logic [GRP_W+SUB_W-1:0]    pixX,
  output logic [LINE_W-1:0]         pixY,
  output logic [IDX_W-1:0]          pixIdx
);
  scanStrb_t         strb;
  logic [GRP_W-1:0]  fetchGrp;
  logic [SUB_W-1:0]  subIdx;

  bpscan_ctrl #(.GRP_W(GRP_W), .LINE_W(LINE_W), .SUB_W(SUB_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .frameStart(frameStart),
    .strb(strb), .fetchGrp(fetchGrp), .xPos(pixX), .subIdx(subIdx), .lineY(pixY)
  );

  bpscan_dp #(.GRP_W(GRP_W), .LINE_W(LINE_W), .SUB_W(SUB_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchGrp(fetchGrp), .subIdx(subIdx),
    .lineY(pixY), .memData(memData), .memRd(memRd), .memAddr(memAddr), .pixIdx(pixIdx)
  );

  assign pixValid = strb.show;

endmodule

// File: rtl/bpscan_chk.sv
module bpscan_chk #(
  parameter int GRP_W  = 6,
  parameter int LINE_W = 8,
  parameter int SUB_W  = 2,
  parameter int IDX_W  = 5
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   memRd,
  input logic [GRP_W+LINE_W:0]  memAddr,
  input logic                   pixValid,
  input logic [GRP_W+SUB_W-1:0] pixX,
  input logic [LINE_W-1:0]      pixY,
  input logic [IDX_W-1:0]       pixIdx
);
  localparam int X_W  = GRP_W + SUB_W;
  localparam int MSB  = GRP_W + LINE_W;
  localparam logic [X_W-1:0] TAILX = X_W'((1 << X_W) - 5);

  AST_BLANK_IDX_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> pixIdx == '0);  // R8

  AST_ATTR_THEN_PIX: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memAddr[MSB]) |=> (memRd && memAddr[MSB] &&
      memAddr[MSB-1:0] == $past(memAddr[MSB-1:0])));  // R4

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixX != '0) |-> ($past(pixValid) && pixX == X_W'($past(pixX) + 1'b1)));  // R2

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(pixValid)) |-> $stable(pixY));  // R3

  AST_NO_RD_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixX >= TAILX) |-> !memRd);  // R5

endmodule

bind bpscan_top bpscan_chk #(.GRP_W(GRP_W), .LINE_W(LINE_W), .SUB_W(SUB_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .memRd(memRd), .memAddr(memAddr), .pixValid(pixValid),
  .pixX(pixX), .pixY(pixY), .pixIdx(pixIdx)
);

// File: tb/bpscan_top_bench.sv
module bpscan_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0;
  logic        frameStart = 1'b0;
  logic        memRd;
  logic [14:0] memAddr;
  logic [7:0]  memData;
  logic        pixValid;
  logic [7:0]  pixX;
  logic [7:0]  pixY;
  logic [4:0]  pixIdx;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bpscan_top u_bpscan_top (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .frameStart(frameStart),
    .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .pixValid(pixValid), .pixX(pixX), .pixY(pixY), .pixIdx(pixIdx)
  );

  function automatic logic [7:0] attrByte(input logic [13:0] a);
    logic [7:0] t;
    t = (a[7:0] ^ {2'b00, a[13:8]}) + 8'd3;
    return t;
  endfunction

  function automatic logic [7:0] pixByte(input logic [13:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd37 + {2'b00, a[13:8]} * 8'd11;
    return t;
  endfunction

  // synchronous framebuffer model, one cycle read latency
  always @(posedge clk) begin
    if (!rstN) memData <= 8'h00;
    else if (memRd) memData <= memAddr[14] ? pixByte(memAddr[13:0]) : attrByte(memAddr[13:0]);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] expIdx(input logic [7:0] x, input logic [7:0] y);
    logic [13:0] a;
    logic [7:0]  at, pb;
    logic [1:0]  n;
    a  = {x[7:2], y};
    at = attrByte(a);
    pb = pixByte(a);
    n  = x[1:0];
    return {at[2:0], pb[3-n], pb[7-n]};
  endfunction

  task automatic runLine(input bit fs, input logic [7:0] expY);
    @(negedge clk);
    lineStart = 1'b1;
    frameStart = fs;
    @(negedge clk);
    lineStart = 1'b0;
    frameStart = 1'b0;
    for (int k = 0; k < 264; k++) begin
      bit expV;
      bit expRd;
      if (k > 0) @(negedge clk);
      expV  = (k >= 3) && (k <= 258);
      expRd = (k < 256) && ((k % 4) < 2);
      chk(pixValid == expV, "R2 valid", pixValid, expV);
      if (expV) begin
        chk(pixX == 8'(k - 3), "R2 x", pixX, k - 3);
        chk(pixY == expY, "R3 y", pixY, expY);
        chk(pixIdx == expIdx(8'(k - 3), expY), "R6 R7 idx", pixIdx, expIdx(8'(k - 3), expY));
      end else begin
        chk(pixIdx == 5'd0, "R8 blank idx", pixIdx, 0);
      end
      chk(memRd == expRd, "R5 read strobe", memRd, expRd);
      if (expRd)
        chk(memAddr == {((k % 4) == 1) ? 1'b1 : 1'b0, 6'(k / 4), expY}, "R4 addr",
            memAddr, {((k % 4) == 1) ? 1'b1 : 1'b0, 6'(k / 4), expY});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pixValid == 1'b0, "R1 valid in reset", pixValid, 0);
    chk(pixIdx == 5'd0, "R1 idx in reset", pixIdx, 0);
    chk(memRd == 1'b0, "R1 read in reset", memRd, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(pixValid == 1'b0, "R1 valid after reset", pixValid, 0);
    chk(pixIdx == 5'd0, "R1 idx after reset", pixIdx, 0);
    chk(memRd == 1'b0, "R1 read after reset", memRd, 0);
    runLine(1'b1, 8'd0);
    for (int l = 1; l < 256; l++) runLine(1'b0, 8'(l));
    runLine(1'b0, 8'd0);   // R3 wrap from 255
    runLine(1'b0, 8'd1);
    runLine(1'b1, 8'd0);   // R3 frame restart mid-count
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule